// File: doc/BRIEF.md
# Serial Line Diagnostic Loopback Router

This block sits between a serial transmitter, a serial receiver and the external line pins. A 16-bit mode register is written and read over a simple register port. It chooses one of four routings of the transmit and receive bit streams: normal, automatic echo, internal loopback and loopback control. It also holds a force-zero control for the line output. From the register setting and the selected line-interface type, the block drives the line transmit pin and its output enable. It forces the auxiliary transmit and request-to-send pins, gates the grant input on its way to the transmitter, and passes the request output through.

The register is the only state in the block. Every routed output is combinational from the register and the live inputs, so a new setting acts in the cycle that follows the write edge. Register bits other than the force-zero and diagnostic fields are stored and read back but steer nothing.

Top module: `sdiag_router`

## Requirements
- R1: On synchronous reset the mode register reads 16'h0000. A write on a rising edge with `cfg_wr` high stores all 16 bits of `cfg_wdata`, and `cfg_rdata` returns them.
- R2: Diagnostic code 2'b00 (register bits 13:12) is normal operation. `line_txd` follows `tx_bit_core`, `rx_bit_core` follows `line_rxd`, `gnt_core` follows `gnt_in`, and `line_txd_oe` is 1.
- R3: Code 2'b01 is automatic echo. `line_txd` and `rx_bit_core` both follow `line_rxd`, so `tx_bit_core` has no effect on the line.
- R4: Code 2'b10 is internal loopback. `rx_bit_core` and `line_txd` both follow `tx_bit_core`, and `line_rxd` has no effect on any output.
- R5: In codes 2'b01 and 2'b10, `gnt_core` is 1 whatever `gnt_in` is. In every code, `req_out` follows `req_core`.
- R6: Code 2'b11 is loopback control. `rx_bit_core` follows `tx_bit_core`, `line_txd` is 1, and both `aux_txd` bits are 1.
- R7: In code 2'b11, all three `rts_out` bits are 1. In the other codes, `rts_out` and `aux_txd` follow their core inputs.
- R8: In code 2'b11, `line_txd_oe` is 0 when `lif_sel` is 2'b01 (IDL) or 2'b10 (PCM), with `line_txd` still holding 1. It is 1 for 2'b00 (NMSI) and 2'b11 (GCI).
- R9: Register bit 15 set with `lif_sel` 2'b11 (GCI) forces `line_txd` to 0 with `line_txd_oe` 1, overriding every diagnostic code. With any other `lif_sel` the bit has no effect.
- R10: After a write edge, every routed output already reflects the new register value before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| lif_sel | input | 2 | Line interface type: 00 NMSI, 01 IDL, 10 PCM, 11 GCI |
| tx_bit_core | input | 1 | Transmit bit from the serial transmitter |
| rx_bit_core | output | 1 | Receive bit to the serial receiver |
| line_rxd | input | 1 | External line receive pin |
| line_txd | output | 1 | External line transmit pin value |
| line_txd_oe | output | 1 | Output enable for line_txd (0 = high impedance) |
| aux_txd_core | input | 2 | Auxiliary transmit bits from their controllers |
| aux_txd | output | 2 | Auxiliary transmit pins |
| rts_core | input | 3 | Request-to-send bits from the controllers |
| rts_out | output | 3 | Request-to-send pins |
| req_core | input | 1 | Line access request from the transmitter |
| req_out | output | 1 | Line access request pin |
| gnt_in | input | 1 | Line access grant pin |
| gnt_core | output | 1 | Grant delivered to the transmitter |

## Verification
Force-zero and the loopback-control pin forcing can act in the same cycle on the same line output. With GCI selected, one forces the pin to 0 and the other to 1. The bench sweeps every combination of force-zero, diagnostic code and interface type against a reference model of the requirements. It judges the combination of bit 15 with code 2'b11 on GCI by expecting a driven 0, and on IDL or PCM by expecting high impedance. A register write and the routing change also coincide. The bench checks the outputs just after the write edge, before the next edge.

// File: rtl/sdiag_pkg.sv
package sdiag_pkg;

    localparam int CFG_W     = 16;
    localparam int FZ_BIT    = 15;
    localparam int DIAG_LSB  = 12;
    localparam int DIAG_W    = 2;
    localparam int N_AUX     = 2;
    localparam int N_RTS     = 3;

    typedef enum logic [DIAG_W-1:0] {
        DIAG_NORMAL  = 2'b00,
        DIAG_ECHO    = 2'b01,
        DIAG_INTLOOP = 2'b10,
        DIAG_LOOPCTL = 2'b11
    } diag_e;

    typedef enum logic [1:0] {
        LIF_NMSI = 2'b00,
        LIF_IDL  = 2'b01,
        LIF_PCM  = 2'b10,
        LIF_GCI  = 2'b11
    } lif_e;

    typedef struct packed {
        logic  force_zero;
        diag_e diag;
    } ctl_s;

    function automatic ctl_s decode_ctl(input logic [CFG_W-1:0] word);
        ctl_s c;
        c.force_zero = word[FZ_BIT];
        c.diag       = diag_e'(word[DIAG_LSB +: DIAG_W]);
        return c;
    endfunction

    function automatic logic lif_floats_in_loopctl(input lif_e t);
        return (t == LIF_IDL) || (t == LIF_PCM);
    endfunction

    function automatic logic grant_bypassed(input diag_e d);
        return (d == DIAG_ECHO) || (d == DIAG_INTLOOP);
    endfunction

endpackage

// File: rtl/sdiag_cfg_reg.sv
module sdiag_cfg_reg
    import sdiag_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> q == '0) else $error("reset value"); // R1
    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> q == $past(wdata)) else $error("write lost"); // R1
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(q)) else $error("spurious change"); // R1

endmodule

// File: rtl/sdiag_data_mux.sv
module sdiag_data_mux
    import sdiag_pkg::*;
(
    input  diag_e diag,
    input  logic  fz_act,
    input  logic  tx_core,
    input  logic  line_rx,
    output logic  line_tx,
    output logic  rx_core
);

    logic routed_tx;

    always_comb begin
        unique case (diag)
            DIAG_NORMAL: begin
                routed_tx = tx_core;
                rx_core   = line_rx;
            end
            DIAG_ECHO: begin
                routed_tx = line_rx;
                rx_core   = line_rx;
            end
            DIAG_INTLOOP: begin
                routed_tx = tx_core;
                rx_core   = tx_core;
            end
            DIAG_LOOPCTL: begin
                routed_tx = 1'b1;
                rx_core   = tx_core;
            end
            default: begin
                routed_tx = tx_core;
                rx_core   = line_rx;
            end
        endcase
    end

    assign line_tx = fz_act ? 1'b0 : routed_tx;

endmodule

// File: rtl/sdiag_pin_ctl.sv
module sdiag_pin_ctl
    import sdiag_pkg::*;
#(
    parameter int NA = N_AUX,
    parameter int NR = N_RTS
) (
    input  diag_e          diag,
    input  lif_e           lif,
    input  logic           fz_act,
    input  logic [NA-1:0]  aux_core,
    input  logic [NR-1:0]  rts_core,
    input  logic           gnt_pin,
    output logic [NA-1:0]  aux_pin,
    output logic [NR-1:0]  rts_pin,
    output logic           gnt_core,
    output logic           line_oe
);

    logic loopctl;
    assign loopctl = (diag == DIAG_LOOPCTL);

    for (genvar i = 0; i < NA; i++) begin : g_aux
        assign aux_pin[i] = loopctl ? 1'b1 : aux_core[i];
    end

    for (genvar j = 0; j < NR; j++) begin : g_rts
        assign rts_pin[j] = loopctl ? 1'b1 : rts_core[j];
    end

    assign gnt_core = grant_bypassed(diag) ? 1'b1 : gnt_pin;
    assign line_oe  = fz_act ? 1'b1 : !(loopctl && lif_floats_in_loopctl(lif));

endmodule

// File: rtl/sdiag_router.sv
module sdiag_router
    import sdiag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic [1:0]       lif_sel,
    input  logic             tx_bit_core,
    output logic             rx_bit_core,
    input  logic             line_rxd,
    output logic             line_txd,
    output logic             line_txd_oe,
    input  logic [1:0]       aux_txd_core,
    output logic [1:0]       aux_txd,
    input  logic [2:0]       rts_core,
    output logic [2:0]       rts_out,
    input  logic             req_core,
    output logic             req_out,
    input  logic             gnt_in,
    output logic             gnt_core
);

    logic [CFG_W-1:0] cfg_q;
    ctl_s             ctl;
    lif_e             lif;
    logic             fz_act;

    sdiag_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign cfg_rdata = cfg_q;
    assign ctl       = decode_ctl(cfg_q);
    assign lif       = lif_e'(lif_sel);
    assign fz_act    = ctl.force_zero && (lif == LIF_GCI);

    sdiag_data_mux u_mux (
        .diag    (ctl.diag),
        .fz_act  (fz_act),
        .tx_core (tx_bit_core),
        .line_rx (line_rxd),
        .line_tx (line_txd),
        .rx_core (rx_bit_core)
    );

    sdiag_pin_ctl #(.NA(N_AUX), .NR(N_RTS)) u_pins (
        .diag     (ctl.diag),
        .lif      (lif),
        .fz_act   (fz_act),
        .aux_core (aux_txd_core),
        .rts_core (rts_core),
        .gnt_pin  (gnt_in),
        .aux_pin  (aux_txd),
        .rts_pin  (rts_out),
        .gnt_core (gnt_core),
        .line_oe  (line_txd_oe)
    );

    assign req_out = req_core;

    AST_LOOP_RX_FROM_TX: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[13] == 1'b1) |-> rx_bit_core == tx_bit_core) else $error("loop rx"); // R4
    AST_ECHO_RX_LINE: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[13:12] == 2'b01 && !fz_act) |-> line_txd == line_rxd) else $error("echo"); // R3
    AST_GRANT_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[13] != cfg_rdata[12]) |-> gnt_core) else $error("grant"); // R5
    AST_RTS_FORCED: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[13:12] == 2'b11) |-> $countones(rts_out) == N_RTS) else $error("rts"); // R7
    AST_FLOAT_ONLY_LOOPCTL: assert property (@(posedge clk) disable iff (rst)
        !line_txd_oe |-> (cfg_rdata[13:12] == 2'b11 && (lif_sel == 2'b01 || lif_sel == 2'b10))) else $error("oe"); // R8
    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] && lif_sel == 2'b11) |-> (!line_txd && line_txd_oe)) else $error("fz"); // R9

endmodule

// File: tb/test_sdiag_router.sv
module test_sdiag_router;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic [1:0]  lif_sel;
    logic        tx_bit_core, line_rxd, req_core, gnt_in;
    logic        rx_bit_core, line_txd, line_txd_oe, req_out, gnt_core;
    logic [1:0]  aux_txd_core, aux_txd;
    logic [2:0]  rts_core, rts_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdiag_router i_sdiag_router (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lif_sel(lif_sel), .tx_bit_core(tx_bit_core), .rx_bit_core(rx_bit_core),
        .line_rxd(line_rxd), .line_txd(line_txd), .line_txd_oe(line_txd_oe),
        .aux_txd_core(aux_txd_core), .aux_txd(aux_txd), .rts_core(rts_core), .rts_out(rts_out),
        .req_core(req_core), .req_out(req_out), .gnt_in(gnt_in), .gnt_core(gnt_core)
    );

    // stimulus {tx, rx, aux[1:0], rts[2:0], req, gnt}
    localparam int NSTIM = 6;
    localparam logic [8:0] STIM [NSTIM] = '{
        9'b1_0_00_000_0_0, 9'b0_1_11_111_1_1, 9'b1_1_01_010_1_0,
        9'b0_0_10_101_0_1, 9'b1_0_11_000_1_1, 9'b0_1_00_111_0_0 };

    // expected {line_txd, oe, rx_core, aux[1:0], rts[2:0], req, gnt}
    function automatic logic [10:0] ref_out(input logic [1:0] code, input logic [1:0] lif,
                                            input logic fz, input logic [8:0] s);
        logic tx, rx, ltx, oe, rxc, g;
        logic [1:0] a;
        logic [2:0] r;
        tx = s[8]; rx = s[7]; a = s[6:5]; r = s[4:2]; g = s[0];
        oe = 1'b1;
        case (code)
            2'b00:   begin ltx = tx; rxc = rx; end
            2'b01:   begin ltx = rx; rxc = rx; g = 1'b1; end
            2'b10:   begin ltx = tx; rxc = tx; g = 1'b1; end
            default: begin ltx = 1'b1; rxc = tx; a = 2'b11; r = 3'b111;
                           oe = !(lif == 2'b01 || lif == 2'b10); end
        endcase
        if (fz && lif == 2'b11) begin ltx = 1'b0; oe = 1'b1; end
        return {ltx, oe, rxc, a, r, s[1], g};
    endfunction

    function automatic string req_tag(input logic [1:0] code, input logic [1:0] lif, input logic fz);
        if (fz && lif == 2'b11) return "R9";
        case (code)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return (lif == 2'b01 || lif == 2'b10) ? "R8" : "R6";
        endcase
    endfunction

    function automatic logic [10:0] observed();
        return {line_txd, line_txd_oe, rx_bit_core, aux_txd, rts_out, req_out, gnt_core};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [8:0] s);
        {tx_bit_core, line_rxd, aux_txd_core, rts_core, req_core, gnt_in} = s;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; lif_sel = 2'b00;
        apply(STIM[2]);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 reset value", cfg_rdata, 16'h0000);
        check("R2 after reset", {5'b0, observed()}, {5'b0, ref_out(2'b00, 2'b00, 1'b0, STIM[2])});

        // full sweep: force-zero x code x interface type x stimulus
        for (int fz = 0; fz < 2; fz++) begin
            for (int code = 0; code < 4; code++) begin
                logic [15:0] w;
                w = 16'h0A5C ^ {fz[0], 1'b0, code[1:0], 12'h000} ^ 16'h0000;
                w[15] = fz[0]; w[13:12] = code[1:0];
                write_cfg(w);
                check("R1 readback", cfg_rdata, w);
                for (int lt = 0; lt < 4; lt++) begin
                    lif_sel = lt[1:0];
                    for (int k = 0; k < NSTIM; k++) begin
                        apply(STIM[k]);
                        #2;
                        check(req_tag(code[1:0], lt[1:0], fz[0]), {5'b0, observed()},
                              {5'b0, ref_out(code[1:0], lt[1:0], fz[0], STIM[k])});
                    end
                end
            end
        end

        // R4: external receive pin ignored in internal loopback
        lif_sel = 2'b00;
        write_cfg(16'h2000);
        apply(9'b1_0_00_000_0_0); #2;
        check("R4 rx ignored lo", {14'b0, rx_bit_core, line_txd}, 16'h0003);
        line_rxd = 1'b1; #2;
        check("R4 rx ignored hi", {14'b0, rx_bit_core, line_txd}, 16'h0003);

        // R5: grant forced in echo, request passes
        write_cfg(16'h1000);
        gnt_in = 1'b0; req_core = 1'b1; #2;
        check("R5 grant echo", {14'b0, gnt_core, req_out}, 16'h0003);

        // R7: rts forced high from all-zero inputs
        write_cfg(16'h3000);
        rts_core = 3'b000; aux_txd_core = 2'b00; #2;
        check("R7 rts forced", {11'b0, rts_out, aux_txd}, 16'h001F);

        // R9: force-zero ignored for NMSI in normal mode
        lif_sel = 2'b00; write_cfg(16'h8000);
        tx_bit_core = 1'b1; #2;
        check("R9 no effect NMSI", {14'b0, line_txd, line_txd_oe}, 16'h0003);

        // R10: outputs follow the register right after the write edge
        lif_sel = 2'b01; tx_bit_core = 1'b0; line_rxd = 1'b1;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 16'h3000;
        @(posedge clk); #1;
        check("R10 same cycle", {13'b0, line_txd_oe, line_txd, rx_bit_core}, 16'h0002);
        @(negedge clk); cfg_wr = 1'b0;

        // R1: write during reset is dropped
        @(negedge clk); rst = 1'b1; cfg_wr = 1'b1; cfg_wdata = 16'hFFFF;
        @(negedge clk); rst = 1'b0; cfg_wr = 1'b0; #2;
        check("R1 reset beats write", cfg_rdata, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule